// File: doc/BRIEF.md
# Programmable 16-bit Timer Channel with Target Compare

This block is a single up-counting timer channel. Software writes a mode word, a count value and a target value through three write strobes that share one data bus, and can read the live count and the mode word at any time. Each tick adds one to the count. A tick is either every system clock or each cycle in which an external strobe is high, such as a pixel-rate pulse, a line pulse or a prescaler output. A halt bit in the mode word stops counting entirely, and the channel comes out of reset halted.

Two events are detected on the tick that causes them. One is the count reaching the target value. The other is the count wrapping from 0xFFFF back to 0. On a target match the count either restarts from zero or runs on to the wrap, as the mode word selects. Each event can request an interrupt, which appears as a single-clock pulse. The interrupt is either one-shot, with only the first qualifying event after a mode write raising it, or repeating. Sticky event flags sit in the upper bits of the mode word and are cleared only by a mode write.

Mode word layout (write bits 9:0 are stored, read bits 12:10 are flags, other bits read as 0): bit 0 halt, bit 3 restart-on-target, bit 4 interrupt-on-target, bit 5 interrupt-on-wrap, bit 6 repeat, bit 8 external tick source, bit 10 any-event flag, bit 11 target-match flag, bit 12 wrap flag.

Top module: `tmr16_timer`

## Requirements
- R1: After reset the count reads 0, the mode word reads 0x0001 (halted, no flags) and the interrupt output is low.
- R2: A mode write stores write bits 9:0, sets the count to 0, clears flag bits 12:10 and clears the interrupt-fired latch; it takes priority over a count write and over a tick in the same cycle.
- R3: With mode bit 0 clear and mode bit 8 clear, the count rises by one on every clock.
- R4: With mode bit 8 set, the count rises by one only in clock cycles where the external tick input is high.
- R5: With mode bit 0 set, the count does not change on any tick.
- R6: A count write loads the written value in place of that cycle's tick and leaves the flags and the fired latch unchanged.
- R7: With mode bit 3 set, the tick that makes the count equal the target loads 0 instead; with a target of 0 the count stays at 0 and every tick is a target match.
- R8: With mode bit 3 clear, the count runs past the target; the tick from 0xFFFF gives 0, a wrap event, and sets bits 12 and 10.
- R9: A target match sets mode bits 11 and 10, which stay set until the next mode write.
- R10: The interrupt output pulses high for one clock on the clock after a target match with bit 4 set or a wrap with bit 5 set, and stays low for events whose enable bit is clear.
- R11: With mode bit 6 clear, only the first enabled event after a mode write raises the interrupt; with bit 6 set, every enabled event does.
- R12: A target write replaces the compare value from the next clock on and does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_we_i | input | 1 | Mode word write strobe |
| cnt_we_i | input | 1 | Count write strobe |
| tgt_we_i | input | 1 | Target write strobe |
| wdata_i | input | 16 | Write data shared by the three strobes |
| alt_tick_i | input | 1 | External tick strobe, used when mode bit 8 is set |
| cnt_o | output | 16 | Current count |
| mode_o | output | 16 | Mode word readback with flags |
| irq_o | output | 1 | Interrupt request, one-clock pulse |

## Verification
Every result of a write or a tick is due at the first rising edge after the cycle that carried it: the count, the flags and the interrupt pulse all change at that one edge, and a new target is used from the edge after its write. The bench drives inputs just after a rising edge and samples all three outputs one nanosecond later, against a behavioural model that applies the same one-edge rule. Directed sequences count ticks to land exactly on target matches and wraps, including a target of 0 and a wrap from 0xFFFF. A long random run then mixes writes, halts and strobes.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  // Mode word bit positions
  localparam int unsigned B_HALT    = 0;
  localparam int unsigned B_RST_TGT = 3;
  localparam int unsigned B_IRQ_TGT = 4;
  localparam int unsigned B_IRQ_OVF = 5;
  localparam int unsigned B_RPT     = 6;
  localparam int unsigned B_ALT_SRC = 8;
  localparam int unsigned CFG_W     = 10;
  localparam int unsigned B_EVT_F   = 10;
  localparam int unsigned B_TGT_F   = 11;
  localparam int unsigned B_OVF_F   = 12;
  localparam int unsigned FLAG_TOP  = 12;

  // Stored configuration value after reset: halted
  localparam logic [CFG_W-1:0] CFG_RST = CFG_W'(1) << B_HALT;

  typedef struct packed {
    logic halt;
    logic rst_tgt;
    logic irq_tgt;
    logic irq_ovf;
    logic rpt;
    logic alt_src;
  } cfg_t;

  function automatic cfg_t decode_cfg(input logic [CFG_W-1:0] raw);
    cfg_t c;
    c.halt    = raw[B_HALT];
    c.rst_tgt = raw[B_RST_TGT];
    c.irq_tgt = raw[B_IRQ_TGT];
    c.irq_ovf = raw[B_IRQ_OVF];
    c.rpt     = raw[B_RPT];
    c.alt_src = raw[B_ALT_SRC];
    return c;
  endfunction

endpackage

// File: rtl/tmr16_tick_sel.sv
module tmr16_tick_sel (
  input  logic halt_i,
  input  logic alt_src_i,
  input  logic alt_tick_i,
  output logic tick_o
);

  logic src_tick;

  always_comb begin
    src_tick = alt_src_i ? alt_tick_i : 1'b1;
    tick_o   = src_tick & ~halt_i;
  end

endmodule

// File: rtl/tmr16_count_core.sv
module tmr16_count_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             tgt_we_i,
  input  logic [CNT_W-1:0] tgt_val_i,
  input  logic             tick_i,
  input  logic             rst_tgt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] tgt_q, tgt_d;
  logic [CNT_W:0]   inc;
  logic             zero_hold, hit_raw, wrap_raw, adv, cnt_en;

  // Next-state logic
  always_comb begin
    inc       = {1'b0, cnt_q} + 1'b1;
    zero_hold = rst_tgt_i && (tgt_q == '0);
    hit_raw   = zero_hold || (inc[CNT_W-1:0] == tgt_q);
    wrap_raw  = inc[CNT_W] && !zero_hold;
    adv       = tick_i && !clr_i && !ld_i;
    cnt_en    = clr_i || ld_i || tick_i;

    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (ld_i) begin
      cnt_d = ld_val_i;
    end else if (tick_i) begin
      if (hit_raw && rst_tgt_i) cnt_d = '0;
      else                      cnt_d = inc[CNT_W-1:0];
    end

    tgt_d  = tgt_val_i;
    hit_o  = adv && hit_raw;
    wrap_o = adv && wrap_raw;
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= '0;
    end else if (tgt_we_i) begin
      tgt_q <= tgt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R3: a plain tick without restart adds one
  a_r3_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && !ld_i && !rst_tgt_i && cnt_q != ALL_ONES)
    |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R5: no tick and no write keeps the count
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i && !ld_i) |=> $stable(cnt_q));

  // R6: count write loads the written value
  a_r6_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !clr_i) |=> (cnt_q == $past(ld_val_i)));

  // R7: target match with restart gives zero
  a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && rst_tgt_i) |=> (cnt_q == '0));

  // R8: wrap leaves the count at zero
  a_r8_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));

  // R12: target write takes the written value
  a_r12_tgt_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_we_i |=> (tgt_q == $past(tgt_val_i)));

endmodule

// File: rtl/tmr16_irq_ctl.sv
module tmr16_irq_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic hit_i,
  input  logic wrap_i,
  input  logic irq_tgt_en_i,
  input  logic irq_ovf_en_i,
  input  logic rpt_i,
  output logic irq_o,
  output logic evt_f_o,
  output logic tgt_f_o,
  output logic ovf_f_o
);

  logic fired_q, fired_d;
  logic irq_q, irq_d;
  logic evt_f_q, evt_f_d;
  logic tgt_f_q, tgt_f_d;
  logic ovf_f_q, ovf_f_d;
  logic req, fire;

  // Next-state logic
  always_comb begin
    req  = (hit_i && irq_tgt_en_i) || (wrap_i && irq_ovf_en_i);
    fire = req && !clr_i && (rpt_i || !fired_q);

    irq_d = fire;
    if (clr_i) begin
      fired_d = 1'b0;
      evt_f_d = 1'b0;
      tgt_f_d = 1'b0;
      ovf_f_d = 1'b0;
    end else begin
      fired_d = fired_q || fire;
      evt_f_d = evt_f_q || hit_i || wrap_i;
      tgt_f_d = tgt_f_q || hit_i;
      ovf_f_d = ovf_f_q || wrap_i;
    end
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fired_q <= 1'b0;
      irq_q   <= 1'b0;
      evt_f_q <= 1'b0;
      tgt_f_q <= 1'b0;
      ovf_f_q <= 1'b0;
    end else begin
      fired_q <= fired_d;
      irq_q   <= irq_d;
      evt_f_q <= evt_f_d;
      tgt_f_q <= tgt_f_d;
      ovf_f_q <= ovf_f_d;
    end
  end

  assign irq_o   = irq_q;
  assign evt_f_o = evt_f_q;
  assign tgt_f_o = tgt_f_q;
  assign ovf_f_o = ovf_f_q;

  // R10: a pulse always follows an enabled event
  a_r10_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past((hit_i && irq_tgt_en_i) || (wrap_i && irq_ovf_en_i)));

  // R11: one-shot mode stays quiet once fired
  a_r11_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fired_q && !rpt_i) |=> !irq_o);

  // R9: target flag is sticky until a mode write
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_f_q && !clr_i) |=> tgt_f_q);

  // R2: mode write clears flags and latch
  a_r2_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!evt_f_q && !tgt_f_q && !ovf_f_q && !fired_q));

endmodule

// File: rtl/tmr16_timer.sv
module tmr16_timer
  import tmr16_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned MODE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic              cnt_we_i,
  input  logic              tgt_we_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic              alt_tick_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              irq_o
);

  localparam int unsigned PAD_W = MODE_W - FLAG_TOP - 1;

  // Reset: asserted at once, released after two clocks
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // Configuration register
  logic [CFG_W-1:0] cfg_q, cfg_d;
  cfg_t             cfg;
  logic             cnt_ld;

  always_comb begin
    cfg_d  = wdata_i[CFG_W-1:0];
    cfg    = decode_cfg(cfg_q);
    cnt_ld = cnt_we_i && !mode_we_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
    end else if (mode_we_i) begin
      cfg_q <= cfg_d;
    end
  end

  logic tick, hit, wrap, evt_f, tgt_f, ovf_f;

  tmr16_tick_sel u_tick (
    .halt_i     (cfg.halt),
    .alt_src_i  (cfg.alt_src),
    .alt_tick_i (alt_tick_i),
    .tick_o     (tick)
  );

  tmr16_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .clr_i     (mode_we_i),
    .ld_i      (cnt_ld),
    .ld_val_i  (wdata_i),
    .tgt_we_i  (tgt_we_i),
    .tgt_val_i (wdata_i),
    .tick_i    (tick),
    .rst_tgt_i (cfg.rst_tgt),
    .cnt_o     (cnt_o),
    .hit_o     (hit),
    .wrap_o    (wrap)
  );

  tmr16_irq_ctl u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .clr_i        (mode_we_i),
    .hit_i        (hit),
    .wrap_i       (wrap),
    .irq_tgt_en_i (cfg.irq_tgt),
    .irq_ovf_en_i (cfg.irq_ovf),
    .rpt_i        (cfg.rpt),
    .irq_o        (irq_o),
    .evt_f_o      (evt_f),
    .tgt_f_o      (tgt_f),
    .ovf_f_o      (ovf_f)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign mode_o = {{PAD_W{1'b0}}, ovf_f, tgt_f, evt_f, cfg_q};
    end else begin : g_nopad
      assign mode_o = {ovf_f, tgt_f, evt_f, cfg_q};
    end
  endgenerate

  // R2: mode write stores the configuration and zeroes the count
  a_r2_mode_write: assert property (@(posedge clk_i) disable iff (!rst_n)
    mode_we_i |=> (cfg_q == $past(wdata_i[CFG_W-1:0]) && cnt_o == '0));

  // R4: external source without a strobe leaves the count alone
  a_r4_alt_gate: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cfg.alt_src && !alt_tick_i && !mode_we_i && !cnt_we_i) |=> $stable(cnt_o));

endmodule

// File: tb/tmr16_timer_tb.sv
`timescale 1ns/1ps
module tmr16_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_we, cnt_we, tgt_we, alt_tick;
  logic [15:0] wdata;
  logic [15:0] cnt_o, mode_o;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  tmr16_timer dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .mode_we_i  (mode_we),
    .cnt_we_i   (cnt_we),
    .tgt_we_i   (tgt_we),
    .wdata_i    (wdata),
    .alt_tick_i (alt_tick),
    .cnt_o      (cnt_o),
    .mode_o     (mode_o),
    .irq_o      (irq_o)
  );

  // Behavioural reference model
  int m_cnt, m_tgt, m_cfg, m_evt, m_thit, m_ovf, m_fired, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_tgt = 0; m_cfg = 1; m_evt = 0; m_thit = 0;
      m_ovf = 0; m_fired = 0; m_irq = 0;
    end else begin
      int  n;
      bit  tk, hit, ov;
      m_irq = 0;
      tk  = !m_cfg[0] && (m_cfg[8] ? alt_tick : 1'b1);
      hit = 0; ov = 0;
      if (mode_we) begin
        m_cfg = int'(wdata) & 'h3FF;
        m_cnt = 0; m_evt = 0; m_thit = 0; m_ovf = 0; m_fired = 0;
      end else if (cnt_we) begin
        m_cnt = int'(wdata);
      end else if (tk) begin
        if (m_cfg[3] && m_tgt == 0) begin
          hit = 1; m_cnt = 0;
        end else begin
          n = m_cnt + 1;
          if (n == 65536) begin ov = 1; n = 0; end
          if (n == m_tgt) hit = 1;
          if (hit && m_cfg[3]) n = 0;
          m_cnt = n;
        end
        if (hit) m_thit = 1;
        if (ov) m_ovf = 1;
        if (hit || ov) m_evt = 1;
        if ((hit && m_cfg[4]) || (ov && m_cfg[5]))
          if (m_cfg[6] || !m_fired) begin m_irq = 1; m_fired = 1; end
      end
      if (tgt_we) m_tgt = int'(wdata);
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      chk(cur_req, "model count", int'(cnt_o), m_cnt);
      chk(cur_req, "model mode", int'(mode_o),
          m_cfg | (m_evt << 10) | (m_thit << 11) | (m_ovf << 12));
      chk(cur_req, "model irq", int'(irq_o), m_irq);
    end
  endtask

  task automatic wr_mode(input int v);
    mode_we = 1'b1; wdata = 16'(v); step(1); mode_we = 1'b0;
  endtask
  task automatic wr_cnt(input int v);
    cnt_we = 1'b1; wdata = 16'(v); step(1); cnt_we = 1'b0;
  endtask
  task automatic wr_tgt(input int v);
    tgt_we = 1'b1; wdata = 16'(v); step(1); tgt_we = 1'b0;
  endtask

  localparam int HALT = 1, RST = 8, ITG = 16, IOV = 32, RPT = 64, ALT = 256;

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_we = 0; cnt_we = 0; tgt_we = 0; alt_tick = 0; wdata = '0;
    #12 rst_n = 1'b1;
    step(4);
    cur_req = "R1";
    chk("R1", "reset count", int'(cnt_o), 0);
    chk("R1", "reset mode", int'(mode_o), 1);
    chk("R1", "reset irq", int'(irq_o), 0);

    cur_req = "R3";
    wr_mode(0); step(5);
    chk("R3", "count after 5 clocks", int'(cnt_o), 5);

    cur_req = "R5";
    wr_mode(HALT); wr_cnt(100); step(4);
    chk("R5", "halted count", int'(cnt_o), 100);
    chk("R6", "loaded count", int'(cnt_o), 100);

    cur_req = "R4";
    wr_mode(ALT);
    alt_tick = 1; step(1); alt_tick = 0; step(1);
    alt_tick = 1; step(2); alt_tick = 0; step(1);
    chk("R4", "count of strobes", int'(cnt_o), 3);

    cur_req = "R7";
    wr_mode(HALT); wr_tgt(10); wr_mode(RST | ITG);
    step(9);
    chk("R7", "count before match", int'(cnt_o), 9);
    chk("R10", "no irq before match", int'(irq_o), 0);
    step(1);
    chk("R7", "restart at target", int'(cnt_o), 0);
    chk("R10", "irq on target", int'(irq_o), 1);
    chk("R9", "target flags", int'(mode_o[11:10]), 3);
    step(1);
    chk("R10", "irq one clock", int'(irq_o), 0);
    cur_req = "R11";
    step(9);
    chk("R11", "second match one-shot", int'(irq_o), 0);
    chk("R9", "flag still set", int'(mode_o[11]), 1);

    wr_mode(HALT); wr_mode(RST | ITG | RPT);
    step(10);
    chk("R11", "repeat first", int'(irq_o), 1);
    step(10);
    chk("R11", "repeat second", int'(irq_o), 1);

    cur_req = "R6";
    wr_cnt('h1234);
    chk("R6", "count write value", int'(cnt_o), 'h1234);
    chk("R6", "flags kept", int'(mode_o[11:10]), 3);
    step(1);
    chk("R6", "counting from load", int'(cnt_o), 'h1235);

    cur_req = "R2";
    wr_mode(HALT | RST);
    chk("R2", "count zeroed", int'(cnt_o), 0);
    chk("R2", "mode readback, flags cleared", int'(mode_o), 9);

    cur_req = "R8";
    wr_tgt(5); wr_mode(IOV); wr_cnt('hFFFE);
    step(1);
    chk("R8", "count at top", int'(cnt_o), 'hFFFF);
    chk("R10", "no irq at top", int'(irq_o), 0);
    step(1);
    chk("R8", "wrap to zero", int'(cnt_o), 0);
    chk("R10", "irq on wrap", int'(irq_o), 1);
    chk("R8", "wrap flags", int'(mode_o[12:10]), 5);
    wr_mode(0); step(5);
    chk("R9", "match without restart", int'(mode_o[11]), 1);
    step(1);
    chk("R8", "runs past target", int'(cnt_o), 6);

    cur_req = "R7";
    wr_mode(HALT); wr_tgt(0); wr_mode(RST | ITG | RPT);
    for (int i = 0; i < 3; i++) begin
      step(1);
      chk("R7", "zero target holds", int'(cnt_o), 0);
      chk("R7", "zero target irq each tick", int'(irq_o), 1);
    end

    cur_req = "R10";
    wr_mode(HALT); wr_tgt(3); wr_mode(RST); step(3);
    chk("R10", "disabled irq", int'(irq_o), 0);
    chk("R9", "flag without irq", int'(mode_o[11]), 1);

    cur_req = "R12";
    wr_mode(HALT); wr_cnt(7); wr_tgt(50);
    chk("R12", "target write keeps count", int'(cnt_o), 7);
    wr_mode(RST); step(49);
    chk("R12", "not yet at new target", int'(cnt_o), 49);
    step(1);
    chk("R12", "new target used", int'(cnt_o), 0);

    cur_req = "random R2 R3 R4 R5 R6 R7 R8 R11";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 256);
      mode_we  = (r < 4);
      cnt_we   = (r >= 4 && r < 10);
      tgt_we   = (r >= 10 && r < 14);
      alt_tick = $urandom % 2;
      if (mode_we)
        wdata = 16'($urandom) & (($urandom % 8 == 0) ? 16'hFFFF : 16'hFFFE);
      else if (tgt_we)
        wdata = 16'($urandom % 40);
      else if (cnt_we)
        wdata = ($urandom % 2) ? 16'(16'hFFF0 + $urandom % 16) : 16'($urandom % 40);
      else
        wdata = 16'($urandom);
      step(1);
    end
    mode_we = 0; cnt_we = 0; tgt_we = 0; alt_tick = 0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule